// File: doc/BRIEF.md
# Clock and RAM Register Window

This block gives a host a single byte-wide window of 64 locations. The lowest eight locations belong to a separate timekeeping core. In order they are seconds, minutes, hours, day of week, day of month, month, year and a control byte. The remaining 56 locations are general-purpose RAM held inside this block. One 6-bit address pointer serves the whole window. The host loads the pointer once and then streams bytes in or out. After every byte the pointer moves up by one. Past the last RAM byte it returns to location zero, the first timekeeping register, and not to the start of RAM.

A write to a timekeeping location is not stored here. It is forwarded to the timekeeping core as a one-cycle strobe carrying the register index and the data. A read of a timekeeping location captures the core's live value for that register. A read of a RAM location returns the stored byte.

Read data comes out one cycle after the read request, together with a valid flag. A small two-state machine produces that flag. `ST_IDLE` means no read data is being presented. `ST_RDOUT` means the data bus carries the result of the previous cycle's read. The transitions are:
- `IDLE_TO_RDOUT`: an accepted read in `ST_IDLE`.
- `RDOUT_STAY`: another accepted read in `ST_RDOUT`.
- `RDOUT_TO_IDLE`: any cycle in `ST_RDOUT` without an accepted read.
- `IDLE_STAY`: any cycle in `ST_IDLE` without an accepted read.

RAM contents have no defined value after power-up, and the host must not rely on them.

Top module: `clock_ram_window`

## Requirements
- R1: A pointer load (`hp_load` high with no access) sets the pointer to the low 6 bits of `hp_addr`; the upper address bits are ignored.
- R2: Every write or read cycle advances the pointer by one, and location 0x3F is followed by 0x00. A cycle with no load and no access leaves the pointer unchanged.
- R3: A write to a location 0x08–0x3F stores the byte in RAM, and a later read of that location returns it.
- R4: A write to a location 0x00–0x07 gives a registered strobe. In the cycle after the write, `tk_wr` is high, `tk_waddr` carries the location's low 3 bits and `tk_wdata` carries the byte. A write to a RAM location leaves `tk_wr` low.
- R5: A read of a location 0x00–0x07 returns the byte that `tk_rdata[8*i+7:8*i]` (i = location) carried in the cycle of the read.
- R6: `hp_rvalid` is high in the cycle after every accepted read and low otherwise. `hp_rdata` holds its value until the next accepted read.
- R7: When `hp_load` coincides with a write or read, the access uses the low 6 bits of `hp_addr` and the pointer then becomes that address plus one.
- R8: When `hp_wr` and `hp_rd` are high in the same cycle, the write is performed, the read is dropped (no `hp_rvalid`), and the pointer advances by exactly one.
- R9: After reset the pointer is 0x00, `hp_rvalid` is low and `tk_wr` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hp_load | input | 1 | Load the pointer from `hp_addr` |
| hp_addr | input | 8 | Load address; only the low 6 bits are used |
| hp_wr | input | 1 | Write `hp_wdata` at the current location |
| hp_rd | input | 1 | Read the current location |
| hp_wdata | input | 8 | Write data |
| hp_rdata | output | 8 | Read data, valid with `hp_rvalid` |
| hp_rvalid | output | 1 | Read data valid, one cycle after the read |
| tk_wr | output | 1 | Write strobe toward the timekeeping core |
| tk_waddr | output | 3 | Timekeeping register index of the write |
| tk_wdata | output | 8 | Timekeeping register write data |
| tk_rdata | input | 64 | Live timekeeping register values, byte i at bits 8i+7..8i |

## Verification
A pointer load can fall in the same cycle as a byte access, and a write can fall in the same cycle as a read. Both collisions are provoked deliberately. A load with a write lands a byte at the loaded address. A load with a read then returns that byte, and a following plain access shows that the pointer ended at the loaded address plus one. A cycle with both write and read must show no valid flag on the next cycle. The next read must come from the following location, and a reload must recover the written byte. Together these show that the write won and the pointer moved only once.

// File: rtl/rcw_pkg.sv
package rcw_pkg;
    localparam int unsigned RCW_DW       = 8;
    localparam int unsigned RCW_AW       = 6;
    localparam int unsigned RCW_HOST_AW  = 8;
    localparam int unsigned RCW_CLK_REGS = 8;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_RDOUT = 1'b1
    } rcw_state_e;
endpackage

// File: rtl/rcw_pointer.sv
module rcw_pointer #(
    parameter int unsigned AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic          step,
    output logic [AW-1:0] ptr_q,
    output logic [AW-1:0] acc_addr
);
    localparam logic [AW-1:0] PTR_ONE = AW'(1);

    // The access in this cycle uses a freshly loaded address if one is offered.
    always_comb begin
        acc_addr = load ? load_addr : ptr_q;
    end

    // The address width makes the wrap from the top location back to 0 free.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (step) begin
            ptr_q <= acc_addr + PTR_ONE;
        end else if (load) begin
            ptr_q <= load_addr;
        end
    end
endmodule

// File: rtl/rcw_decode.sv
module rcw_decode #(
    parameter int unsigned AW       = 6,
    parameter int unsigned DW       = 8,
    parameter int unsigned CLK_REGS = 8,
    localparam int unsigned CIW     = $clog2(CLK_REGS)
) (
    input  logic [AW-1:0]          addr,
    input  logic [CLK_REGS*DW-1:0] tk_rdata,
    output logic                   is_clk,
    output logic [CIW-1:0]         clk_idx,
    output logic [AW-1:0]          ram_idx,
    output logic [DW-1:0]          tk_byte
);
    localparam logic [AW-1:0] CLK_SPAN = AW'(CLK_REGS);

    logic [DW-1:0] tk_arr [CLK_REGS];

    for (genvar g = 0; g < CLK_REGS; g++) begin : g_unpack
        assign tk_arr[g] = tk_rdata[g*DW +: DW];
    end

    always_comb begin
        is_clk  = (addr < CLK_SPAN);
        clk_idx = addr[CIW-1:0];
        ram_idx = addr - CLK_SPAN;
        tk_byte = tk_arr[clk_idx];
    end
endmodule

// File: rtl/rcw_ram.sv
module rcw_ram #(
    parameter int unsigned DW    = 8,
    parameter int unsigned AW    = 6,
    parameter int unsigned DEPTH = 56
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata_q
);
    // The store has no reset: its power-up contents are undefined by intent.
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        if (re) begin
            rdata_q <= mem[raddr];
        end
    end
endmodule

// File: rtl/clock_ram_window.sv
module clock_ram_window
    import rcw_pkg::*;
#(
    parameter int unsigned DW       = RCW_DW,
    parameter int unsigned AW       = RCW_AW,
    parameter int unsigned HOST_AW  = RCW_HOST_AW,
    parameter int unsigned CLK_REGS = RCW_CLK_REGS,
    localparam int unsigned CIW     = $clog2(CLK_REGS),
    localparam int unsigned DEPTH   = (1 << AW) - CLK_REGS
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   hp_load,
    input  logic [HOST_AW-1:0]     hp_addr,
    input  logic                   hp_wr,
    input  logic                   hp_rd,
    input  logic [DW-1:0]          hp_wdata,
    output logic [DW-1:0]          hp_rdata,
    output logic                   hp_rvalid,
    output logic                   tk_wr,
    output logic [CIW-1:0]         tk_waddr,
    output logic [DW-1:0]          tk_wdata,
    input  logic [CLK_REGS*DW-1:0] tk_rdata
);
    logic           unused_addr_hi;
    logic           step;
    logic           rd_take;
    logic [AW-1:0]  ptr_q;
    logic [AW-1:0]  acc_addr;
    logic           acc_is_clk;
    logic [CIW-1:0] acc_clk_idx;
    logic [AW-1:0]  acc_ram_idx;
    logic [DW-1:0]  acc_tk_byte;
    logic [DW-1:0]  ram_rdata;
    logic           sel_clk_q;
    logic [DW-1:0]  tk_byte_q;
    rcw_state_e     state_q, state_d;

    assign unused_addr_hi = ^hp_addr[HOST_AW-1:AW];

    // A write takes precedence over a read offered in the same cycle.
    assign step    = hp_wr | hp_rd;
    assign rd_take = hp_rd & ~hp_wr;

    rcw_pointer #(.AW(AW)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (hp_load),
        .load_addr (hp_addr[AW-1:0]),
        .step      (step),
        .ptr_q     (ptr_q),
        .acc_addr  (acc_addr)
    );

    rcw_decode #(.AW(AW), .DW(DW), .CLK_REGS(CLK_REGS)) u_dec (
        .addr     (acc_addr),
        .tk_rdata (tk_rdata),
        .is_clk   (acc_is_clk),
        .clk_idx  (acc_clk_idx),
        .ram_idx  (acc_ram_idx),
        .tk_byte  (acc_tk_byte)
    );

    rcw_ram #(.DW(DW), .AW(AW), .DEPTH(DEPTH)) u_ram (
        .clk     (clk),
        .we      (hp_wr & ~acc_is_clk),
        .waddr   (acc_ram_idx),
        .wdata   (hp_wdata),
        .re      (rd_take & ~acc_is_clk),
        .raddr   (acc_ram_idx),
        .rdata_q (ram_rdata)
    );

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: IDLE_TO_RDOUT, RDOUT_STAY, RDOUT_TO_IDLE, IDLE_STAY.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = rd_take ? ST_RDOUT : ST_IDLE;
            ST_RDOUT: state_d = rd_take ? ST_RDOUT : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Read capture: the source flag and the live timekeeping byte.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_clk_q <= 1'b0;
            tk_byte_q <= '0;
        end else if (rd_take) begin
            sel_clk_q <= acc_is_clk;
            if (acc_is_clk) begin
                tk_byte_q <= acc_tk_byte;
            end
        end
    end

    // Write strobe toward the timekeeping core, one cycle after the write.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tk_wr    <= 1'b0;
            tk_waddr <= '0;
            tk_wdata <= '0;
        end else begin
            tk_wr <= hp_wr & acc_is_clk;
            if (hp_wr & acc_is_clk) begin
                tk_waddr <= acc_clk_idx;
                tk_wdata <= hp_wdata;
            end
        end
    end

    // Outputs from state.
    always_comb begin
        hp_rvalid = (state_q == ST_RDOUT);
        hp_rdata  = sel_clk_q ? tk_byte_q : ram_rdata;
    end
endmodule

// File: rtl/rcw_checker.sv
module rcw_checker #(
    parameter int unsigned DW  = 8,
    parameter int unsigned AW  = 6,
    parameter int unsigned CIW = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           hp_load,
    input logic [AW-1:0]  ld_addr,
    input logic           hp_wr,
    input logic           hp_rd,
    input logic [DW-1:0]  hp_wdata,
    input logic           hp_rvalid,
    input logic           tk_wr,
    input logic [CIW-1:0] tk_waddr,
    input logic [DW-1:0]  tk_wdata,
    input logic [AW-1:0]  ptr_q
);
    localparam logic [AW-1:0] ONE      = AW'(1);
    localparam logic [AW-1:0] CLK_SPAN = AW'(1 << CIW);

    assert_load_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (hp_load && !hp_wr && !hp_rd) |=> (ptr_q == $past(ld_addr)));

    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!hp_load && (hp_wr || hp_rd)) |=> (ptr_q == $past(ptr_q) + ONE));

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!hp_load && !hp_wr && !hp_rd) |=> $stable(ptr_q));

    assert_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hp_wr && !hp_load && (ptr_q < CLK_SPAN)) |=>
            (tk_wr && (tk_waddr == $past(ptr_q[CIW-1:0])) && (tk_wdata == $past(hp_wdata))));

    assert_no_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !hp_wr |=> !tk_wr);

    assert_rvalid_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hp_rd && !hp_wr) |=> hp_rvalid);

    assert_rvalid_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(hp_rd && !hp_wr) |=> !hp_rvalid);

    assert_load_access_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hp_load && (hp_wr || hp_rd)) |=> (ptr_q == $past(ld_addr) + ONE));
endmodule

bind clock_ram_window rcw_checker #(.DW(DW), .AW(AW), .CIW(CIW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hp_load   (hp_load),
    .ld_addr   (hp_addr[AW-1:0]),
    .hp_wr     (hp_wr),
    .hp_rd     (hp_rd),
    .hp_wdata  (hp_wdata),
    .hp_rvalid (hp_rvalid),
    .tk_wr     (tk_wr),
    .tk_waddr  (tk_waddr),
    .tk_wdata  (tk_wdata),
    .ptr_q     (ptr_q)
);

// File: tb/clock_ram_window_tb.sv
module clock_ram_window_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hp_load = 1'b0;
    logic [7:0]  hp_addr = '0;
    logic        hp_wr = 1'b0;
    logic        hp_rd = 1'b0;
    logic [7:0]  hp_wdata = '0;
    logic [7:0]  hp_rdata;
    logic        hp_rvalid;
    logic        tk_wr;
    logic [2:0]  tk_waddr;
    logic [7:0]  tk_wdata;
    logic [63:0] tk_rdata;

    logic [7:0]  tk_model [8];
    logic        poke = 1'b0;
    logic [2:0]  poke_idx = '0;
    logic [7:0]  poke_val = '0;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    clock_ram_window u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .hp_load   (hp_load),
        .hp_addr   (hp_addr),
        .hp_wr     (hp_wr),
        .hp_rd     (hp_rd),
        .hp_wdata  (hp_wdata),
        .hp_rdata  (hp_rdata),
        .hp_rvalid (hp_rvalid),
        .tk_wr     (tk_wr),
        .tk_waddr  (tk_waddr),
        .tk_wdata  (tk_wdata),
        .tk_rdata  (tk_rdata)
    );

    // Minimal timekeeping core: it holds eight bytes and accepts strobes.
    initial begin
        for (int i = 0; i < 8; i++) tk_model[i] = 8'hA0 + 8'(i);
    end

    always @(posedge clk) begin
        if (poke) tk_model[poke_idx] <= poke_val;
        else if (tk_wr) tk_model[tk_waddr] <= tk_wdata;
    end

    for (genvar i = 0; i < 8; i++) begin : g_tk
        assign tk_rdata[8*i +: 8] = tk_model[i];
    end

    function automatic logic [7:0] burst_val(int i);
        return 8'(i * 37 + 11);
    endfunction

    function automatic logic [7:0] sweep_val(int a);
        return 8'(a) ^ 8'h96;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    // Apply one cycle of host inputs; returns at the falling edge after the capture edge.
    task automatic drive(logic l, logic [7:0] a, logic w, logic r, logic [7:0] d);
        hp_load  = l;
        hp_addr  = a;
        hp_wr    = w;
        hp_rd    = r;
        hp_wdata = d;
        @(negedge clk);
        hp_load = 1'b0;
        hp_wr   = 1'b0;
        hp_rd   = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 reset state
        chk("R9 rvalid after reset", 32'(hp_rvalid), 0);
        chk("R9 tk_wr after reset", 32'(tk_wr), 0);
        drive(1'b0, 8'h00, 1'b0, 1'b1, 8'h00);
        chk("R9 pointer starts at 0 (R5 live byte 0)", 32'(hp_rdata), 32'h0A0);
        chk("R6 rvalid after read", 32'(hp_rvalid), 1);

        // R1 upper load bits are masked
        drive(1'b1, 8'hC9, 1'b0, 1'b0, 8'h00);
        chk("R6 rvalid low after load", 32'(hp_rvalid), 0);
        drive(1'b0, 8'h00, 1'b1, 1'b0, 8'h5A);
        chk("R4 no strobe for RAM write", 32'(tk_wr), 0);
        drive(1'b1, 8'h49, 1'b0, 1'b0, 8'h00);
        drive(1'b0, 8'h00, 1'b0, 1'b1, 8'h00);
        chk("R1 masked load reaches 0x09", 32'(hp_rdata), 32'h5A);

        // R2 R3 R4 burst of 60 bytes from 0x3C, wrapping through the clock registers
        drive(1'b1, 8'h3C, 1'b0, 1'b0, 8'h00);
        for (int i = 0; i < 60; i++) begin
            int a;
            a = (8'h3C + i) % 64;
            drive(1'b0, 8'h00, 1'b1, 1'b0, burst_val(i));
            if (a < 8) begin
                chk($sformatf("R4 strobe at %0h", a), 32'(tk_wr), 1);
                chk($sformatf("R4 index at %0h", a), 32'(tk_waddr), 32'(a));
                chk($sformatf("R4 data at %0h", a), 32'(tk_wdata), 32'(burst_val(i)));
            end else begin
                chk($sformatf("R4 no strobe at %0h", a), 32'(tk_wr), 0);
            end
        end
        idle();
        drive(1'b1, 8'h3C, 1'b0, 1'b0, 8'h00);
        for (int i = 0; i < 60; i++) begin
            drive(1'b0, 8'h00, 1'b0, 1'b1, 8'h00);
            chk($sformatf("R2 R3 burst read %0d", i), 32'(hp_rdata), 32'(burst_val(i)));
            chk("R6 rvalid in burst", 32'(hp_rvalid), 1);
        end

        // R2 wrap after 0x3F lands on location 0
        drive(1'b1, 8'h3F, 1'b0, 1'b0, 8'h00);
        drive(1'b0, 8'h00, 1'b0, 1'b1, 8'h00);
        chk("R2 read of 0x3F", 32'(hp_rdata), 32'(burst_val(3)));
        drive(1'b0, 8'h00, 1'b0, 1'b1, 8'h00);
        chk("R2 wrap to 0x00", 32'(hp_rdata), 32'(burst_val(4)));

        // R5 live value from the core
        poke_idx = 3'd5; poke_val = 8'hC3; poke = 1'b1;
        @(negedge clk);
        poke = 1'b0;
        drive(1'b1, 8'h05, 1'b0, 1'b1, 8'h00);
        chk("R5 live read of 0x05", 32'(hp_rdata), 32'hC3);

        // R3 near-exhaustive sweep of all 64 locations
        drive(1'b1, 8'h00, 1'b0, 1'b0, 8'h00);
        for (int a = 0; a < 64; a++) drive(1'b0, 8'h00, 1'b1, 1'b0, sweep_val(a));
        idle();
        drive(1'b1, 8'h00, 1'b0, 1'b0, 8'h00);
        for (int a = 0; a < 64; a++) begin
            drive(1'b0, 8'h00, 1'b0, 1'b1, 8'h00);
            chk($sformatf("R3 sweep at %0h", a), 32'(hp_rdata), 32'(sweep_val(a)));
        end

        // R7 load in the same cycle as an access
        drive(1'b1, 8'h20, 1'b1, 1'b0, 8'h11);
        drive(1'b0, 8'h00, 1'b1, 1'b0, 8'h22);
        drive(1'b1, 8'h20, 1'b0, 1'b1, 8'h00);
        chk("R7 load+read data", 32'(hp_rdata), 32'h11);
        drive(1'b0, 8'h00, 1'b0, 1'b1, 8'h00);
        chk("R7 pointer after load+access", 32'(hp_rdata), 32'h22);

        // R8 write and read together
        drive(1'b1, 8'h30, 1'b0, 1'b0, 8'h00);
        drive(1'b0, 8'h00, 1'b1, 1'b1, 8'h77);
        chk("R8 read dropped", 32'(hp_rvalid), 0);
        drive(1'b0, 8'h00, 1'b0, 1'b1, 8'h00);
        chk("R8 pointer moved once", 32'(hp_rdata), 32'(sweep_val(8'h31)));
        drive(1'b1, 8'h30, 1'b0, 1'b1, 8'h00);
        chk("R8 write performed", 32'(hp_rdata), 32'h77);

        // R6 data holds through idle cycles
        idle();
        chk("R6 rvalid low when idle", 32'(hp_rvalid), 0);
        idle();
        chk("R6 rdata holds", 32'(hp_rdata), 32'h77);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule